// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers 64 interrupt request lines into one CPU interrupt. The lines are split into two banks of 32. In each bank, some bits are latched on a rising edge and stay pending until software clears them. The other bits are level-sensitive and follow the live input. A fixed map per bank says which bits are level-sensitive: bank 0 has none, and bank 1 treats bits 20 to 28 as level-sensitive. The bank numbering is inverted with respect to the inputs. Inputs 0 to 31 feed bank 1 and inputs 32 to 63 feed bank 0, and within a bank the bit index is the input number modulo 32.

Software uses a small synchronous register bus with a 12-bit byte address. Bank b occupies 16 bytes starting at 0x10 + 16*b. Within a bank there are four registers:
- the pending-event word, read-only;
- the enable mask, read and write;
- a write-one-to-clear port for the events;
- the registered input levels, read-only.

Data words are byte-reversed between the bus and the internal registers in both directions. A bank asks for service when (events OR (levels AND levelMap)) AND mask is non-zero. The CPU interrupt is the registered OR of both banks' requests.

Top module: `dbic_top`

## Requirements
- R1: Input i with i below 32 drives bit i of bank 1, and input i with i of 32 or more drives bit i-32 of bank 0.
- R2: The levels register of a bank (offset 0xC) reads the input values captured at the most recent clock edge.
- R3: An edge-mode bit sets its event on a 0-to-1 change of the registered input. It then stays set until it is cleared, and a clear issued while the input stays high keeps the bit at 0.
- R4: Level-mode bits never set their event bit. They request service for as long as the captured level is 1 and the bit is enabled in the mask.
- R5: `cpuIrq` equals the OR of both banks' (events | (levels & levelMap)) & mask, as computed from the register state of the previous cycle.
- R6: A write to offset 0x4 replaces the bank's mask, and a read of offset 0x4 returns the mask.
- R7: A write to offset 0x8 clears every edge-mode event bit where the internal data is 1. If an event sets and is cleared in the same cycle, the set wins.
- R8: A read from an address outside 0x010 to 0x02F returns 0, and a write there changes nothing. This includes addresses below 0x010.
- R9: Within a bank, any offset other than 0x0, 0x4, 0x8 and 0xC reads as 0. Writes to the events, the levels, or any other offset change nothing.
- R10: The internal word is the byte reversal of the bus word, both for writes and for reads. For example, bus value 0x08000000 corresponds to internal bit 3.
- R11: `busRdata` is 0 whenever `busRe` is low.
- R12: A synchronous high `rst` clears the events, the mask, the captured levels and `cpuIrq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | 64 | Interrupt request levels |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data, bus byte order |
| busRdata | output | 32 | Read data, bus byte order; 0 when no read |
| cpuIrq | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions check the following on every cycle:
- a level-mode bit never holds an event;
- a captured rising edge always lands in the event word;
- a clear leaves no cleared bit set unless a new edge arrived;
- `cpuIrq` tracks the banks' requests one cycle late;
- idle reads and reads outside the window return zero.

Only the bench scenarios can show the rest:
- the inverted bank-to-input mapping;
- the byte-reversed mask affecting which inputs can interrupt;
- a set winning over a clear in the same cycle;
- writes to read-only or undecoded addresses changing nothing.

The bench shows these by reading the state back over the bus and by watching the interrupt.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int IRQ_W     = BANK_W * NUM_BANKS;
  localparam int ADDR_W    = 12;
  localparam int IDX_W     = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] WIN_BASE = 12'h010;

  localparam logic [3:0] OFF_EVENTS = 4'h0;
  localparam logic [3:0] OFF_MASK   = 4'h4;
  localparam logic [3:0] OFF_CLEAR  = 4'h8;
  localparam logic [3:0] OFF_LEVELS = 4'hC;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankHit;
    logic wrMask;
    logic wrClear;
    logic rdEvents;
    logic rdMask;
    logic rdLevels;
  } ctrlStrobe_t;

  function automatic logic [BANK_W-1:0] byteRev(input logic [BANK_W-1:0] d);
    for (int k = 0; k < BANK_W / 8; k++) begin
      byteRev[k*8 +: 8] = d[(BANK_W/8 - 1 - k)*8 +: 8];
    end
  endfunction
endpackage

// File: rtl/dbic_ctrl.sv
module dbic_ctrl
  import dbic_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output ctrlStrobe_t       strb
);
  logic [ADDR_W-1:0] relAddr;
  logic [IDX_W-1:0]  bankIdx;
  logic [3:0]        regOff;
  logic              anyHit;

  // Bank index from the window base; addresses below the base wrap to a large index.
  assign relAddr = busAddr - WIN_BASE;
  assign bankIdx = relAddr[ADDR_W-1:4];
  assign regOff  = busAddr[3:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign strb.bankHit[b] = (bankIdx == IDX_W'(b));
  end

  assign anyHit        = |strb.bankHit;
  assign strb.wrMask   = busWe & anyHit & (regOff == OFF_MASK);
  assign strb.wrClear  = busWe & anyHit & (regOff == OFF_CLEAR);
  assign strb.rdEvents = busRe & anyHit & (regOff == OFF_EVENTS);
  assign strb.rdMask   = busRe & anyHit & (regOff == OFF_MASK);
  assign strb.rdLevels = busRe & anyHit & (regOff == OFF_LEVELS);
endmodule

// File: rtl/dbic_bank.sv
module dbic_bank #(
  parameter int              W        = 32,
  parameter logic [W-1:0]    LVL_TRIG = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] irqBank,
  input  logic         wrMask,
  input  logic         wrClear,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] evQ,
  output logic [W-1:0] maskQ,
  output logic [W-1:0] levQ,
  output logic         bankReq
);
  logic [W-1:0] riseVec;
  logic [W-1:0] clrVec;

  assign riseVec = irqBank & ~levQ & ~LVL_TRIG;
  assign clrVec  = wrClear ? (wrData & ~LVL_TRIG) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      evQ   <= '0;
      maskQ <= '0;
      levQ  <= '0;
    end else begin
      evQ  <= (evQ & ~clrVec) | riseVec;
      levQ <= irqBank;
      if (wrMask) maskQ <= wrData;
    end
  end

  assign bankReq = |((evQ | (levQ & LVL_TRIG)) & maskQ);

  assert_level_no_event_R4: assert property (@(posedge clk) disable iff (rst)
    (evQ & LVL_TRIG) == '0);

  assert_rise_latched_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evQ & $past(riseVec)) == $past(riseVec)));

  assert_clear_effective_R7: assert property (@(posedge clk) disable iff (rst)
    wrClear |=> ((evQ & $past(clrVec) & ~$past(riseVec)) == '0));
endmodule

// File: rtl/dbic_datapath.sv
module dbic_datapath
  import dbic_pkg::*;
#(
  parameter logic [BANK_W-1:0] LVL_TRIG_B0 = '0,
  parameter logic [BANK_W-1:0] LVL_TRIG_B1 = 32'h1FF0_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IRQ_W-1:0]     irqIn,
  input  ctrlStrobe_t          strb,
  input  logic [BANK_W-1:0]    busWdata,
  output logic [BANK_W-1:0]    busRdata,
  output logic [NUM_BANKS-1:0] bankReq
);
  logic [BANK_W-1:0] wrInt;
  logic [BANK_W-1:0] evArr   [NUM_BANKS];
  logic [BANK_W-1:0] maskArr [NUM_BANKS];
  logic [BANK_W-1:0] levArr  [NUM_BANKS];
  logic [BANK_W-1:0] rdInt;

  assign wrInt = byteRev(busWdata);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // Inverted mapping: the highest input slice feeds bank 0.
    localparam int SLICE = NUM_BANKS - 1 - b;
    localparam logic [BANK_W-1:0] LT = (b == 1) ? LVL_TRIG_B1 : LVL_TRIG_B0;
    dbic_bank #(.W(BANK_W), .LVL_TRIG(LT)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .irqBank (irqIn[SLICE*BANK_W +: BANK_W]),
      .wrMask  (strb.wrMask & strb.bankHit[b]),
      .wrClear (strb.wrClear & strb.bankHit[b]),
      .wrData  (wrInt),
      .evQ     (evArr[b]),
      .maskQ   (maskArr[b]),
      .levQ    (levArr[b]),
      .bankReq (bankReq[b])
    );
  end

  always_comb begin
    rdInt = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bankHit[b]) begin
        if (strb.rdEvents) rdInt = rdInt | evArr[b];
        if (strb.rdMask)   rdInt = rdInt | maskArr[b];
        if (strb.rdLevels) rdInt = rdInt | levArr[b];
      end
    end
  end

  assign busRdata = byteRev(rdInt);
endmodule

// File: rtl/dbic_top.sv
module dbic_top
  import dbic_pkg::*;
#(
  parameter logic [BANK_W-1:0] LVL_TRIG_B0 = '0,
  parameter logic [BANK_W-1:0] LVL_TRIG_B1 = 32'h1FF0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IRQ_W-1:0]  irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  output logic              cpuIrq
);
  ctrlStrobe_t          strb;
  logic [NUM_BANKS-1:0] bankReq;

  dbic_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strb    (strb)
  );

  dbic_datapath #(.LVL_TRIG_B0(LVL_TRIG_B0), .LVL_TRIG_B1(LVL_TRIG_B1)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .irqIn    (irqIn),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .bankReq  (bankReq)
  );

  always_ff @(posedge clk) begin
    if (rst) cpuIrq <= 1'b0;
    else     cpuIrq <= |bankReq;
  end

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpuIrq == $past(|bankReq)));

  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !busRe |-> (busRdata == '0));

  assert_outside_window_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (busRe && busAddr[ADDR_W-1:4] != 8'h01 && busAddr[ADDR_W-1:4] != 8'h02)
      |-> (busRdata == '0));
endmodule

// File: tb/dbic_top_tb_top.sv
`timescale 1ns/1ps
module dbic_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irqVec = '0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cpuIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbic_top dut_i (
    .clk(clk), .rst(rst), .irqIn(irqVec), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata), .cpuIrq(cpuIrq)
  );

  localparam logic [31:0] LT1 = 32'h1FF0_0000;

  function automatic logic [31:0] swap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // Expected state, built from the requirements.
  logic [31:0] mEv [2];
  logic [31:0] mMask [2];
  logic [31:0] mLev [2];
  logic        mIrq;

  function automatic int bankOf(input logic [11:0] a);
    if (a[11:4] == 8'h01) return 0;
    if (a[11:4] == 8'h02) return 1;
    return -1;
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a, input logic re);
    int b;
    b = bankOf(a);
    if (!re || b < 0) return 32'h0;
    case (a[3:0])
      4'h0:    return swap(mEv[b]);
      4'h4:    return swap(mMask[b]);
      4'hC:    return swap(mLev[b]);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] inB, lt, rise, clr;
    logic req;
    req = 1'b0;
    for (int b = 0; b < 2; b++) begin
      req = req | (|((mEv[b] | (mLev[b] & ((b == 1) ? LT1 : 32'h0))) & mMask[b]));
    end
    for (int b = 0; b < 2; b++) begin
      inB  = (b == 0) ? irqVec[63:32] : irqVec[31:0];
      lt   = (b == 1) ? LT1 : 32'h0;
      rise = inB & ~mLev[b] & ~lt;
      clr  = (busWe && bankOf(busAddr) == b && busAddr[3:0] == 4'h8) ? (swap(busWdata) & ~lt) : 32'h0;
      if (rst) begin
        mEv[b] <= '0; mMask[b] <= '0; mLev[b] <= '0;
      end else begin
        mEv[b]  <= (mEv[b] & ~clr) | rise;
        mLev[b] <= inB;
        if (busWe && bankOf(busAddr) == b && busAddr[3:0] == 4'h4) mMask[b] <= swap(busWdata);
      end
    end
    mIrq <= rst ? 1'b0 : req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busRe = 1'b1;
    #1;
    chk(tag, busRdata, exp);
    busRe = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    tick();
    busWe = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) tick();
    // R12: reset state
    rd(12'h010, 0, "R12 ev0");  rd(12'h014, 0, "R12 mask0"); rd(12'h01C, 0, "R12 lev0");
    rd(12'h020, 0, "R12 ev1");  rd(12'h024, 0, "R12 mask1"); rd(12'h02C, 0, "R12 lev1");
    chk("R12 cpuIrq", {31'b0, cpuIrq}, 0);
    rst = 1'b0;
    tick();

    // R1/R2/R3: input 3 goes to bank 1 bit 3
    irqVec[3] = 1'b1;
    tick();
    rd(12'h02C, 32'h0800_0000, "R1 R2 bank1 levels");
    rd(12'h01C, 32'h0, "R1 bank0 levels untouched");
    rd(12'h020, 32'h0800_0000, "R3 bank1 event latched");
    chk("R5 masked off", {31'b0, cpuIrq}, 0);

    // R10: bus 0x00000008 is internal bit 27, not bit 3
    wr(12'h024, 32'h0000_0008);
    tick();
    chk("R10 swapped mask no irq", {31'b0, cpuIrq}, 0);
    rd(12'h024, 32'h0000_0008, "R6 R10 mask readback");
    wr(12'h024, 32'h0800_0000);
    chk("R5 irq not yet", {31'b0, cpuIrq}, 0);
    tick();
    chk("R5 R10 irq asserted", {31'b0, cpuIrq}, 1);

    // R7/R3: clear while input stays high
    wr(12'h028, 32'h0800_0000);
    rd(12'h020, 32'h0, "R7 event cleared");
    tick();
    rd(12'h020, 32'h0, "R3 no re-latch while high");
    chk("R5 irq dropped", {31'b0, cpuIrq}, 0);

    // R4: level-mode bit 20 of bank 1
    irqVec[20] = 1'b1;
    wr(12'h024, 32'h0000_1000);
    rd(12'h020, 32'h0, "R4 level bit no event");
    rd(12'h02C, 32'h0810_0000 >> 0 == 0 ? 0 : swap(32'h0010_0008), "R4 R2 levels");
    tick();
    chk("R4 level irq", {31'b0, cpuIrq}, 1);
    irqVec[20] = 1'b0;
    tick();
    chk("R4 irq still one cycle", {31'b0, cpuIrq}, 1);
    tick();
    chk("R4 irq follows level low", {31'b0, cpuIrq}, 0);
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0, "R7 clear all");

    // R7: set wins over clear in the same cycle
    irqVec[3] = 1'b0;
    tick();
    irqVec[3] = 1'b1;
    wr(12'h028, 32'h0800_0000);
    rd(12'h020, 32'h0800_0000, "R7 set wins");

    // R8: outside the window
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h034, 32'h0, "R8 bank index 2 reads zero");
    rd(12'h004, 32'h0, "R8 below base reads zero");
    rd(12'h014, 32'h0, "R8 bank0 mask untouched");
    rd(12'h024, 32'h0000_1000, "R8 bank1 mask untouched");
    rd(12'h020, 32'h0800_0000, "R8 bank1 events untouched");

    // R9: undecoded offsets and read-only registers
    rd(12'h028, 32'h0, "R9 clear reads zero");
    rd(12'h021, 32'h0, "R9 odd offset zero");
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h02C, 32'h0);
    wr(12'h026, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0800_0000, "R9 events read-only");
    rd(12'h02C, 32'h0800_0000, "R9 levels read-only");
    rd(12'h024, 32'h0000_1000, "R9 mask untouched by odd offset");

    // R11: no strobe, no data
    busAddr = 12'h020; busRe = 1'b0;
    #1;
    chk("R11 idle read", busRdata, 0);

    // R1: input 35 to bank 0 bit 3
    irqVec[35] = 1'b1;
    tick();
    rd(12'h01C, 32'h0800_0000, "R1 bank0 levels");
    rd(12'h010, 32'h0800_0000, "R1 bank0 event");
    rd(12'h02C, 32'h0800_0000, "R1 bank1 levels unchanged");

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      @(negedge clk);
      #1;
      chk("R2 R6 R9 random read", busRdata, expRead(busAddr, busRe));
      chk("R5 random irq", {31'b0, cpuIrq}, {31'b0, mIrq});
      irqVec = irqVec ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      r = $urandom;
      case (r[3:0])
        4'h0, 4'h1: busAddr = 12'h010 + 12'(r[5:4]) * 4;
        4'h2, 4'h3: busAddr = 12'h020 + 12'(r[5:4]) * 4;
        4'h4:       busAddr = 12'(r[15:4]);
        default:    busAddr = (r[6] ? 12'h020 : 12'h010) + 12'(r[9:7]) * 4;
      endcase
      busRe    = r[10];
      busWe    = (r[13:11] == 3'b000);
      busWdata = $urandom;
    end
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0;

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule